// File: doc/BRIEF.md
# Bus Access Protection Break Monitor

This block sits beside an external memory bus and watches every access: the address, the read and write strobes and a vector of active-high chip-enable lines. Each access is judged by three independent rules. The first rule checks the access against a two-bit permission that is kept for each chip enable. The second checks it against a bitmap with one enable bit for each 32KB slice of the address space. The third flags any strobe that arrives while no chip enable is asserted. A violation is turned into a two-bit cause code.

The cause code travels down a short pipeline that advances only on bus accesses. It surfaces as a one-cycle break pulse three accesses later, which mirrors a monitor that can only report what it has seen on the pins. One chip enable is set aside for the monitor's own registers and is never judged. A window of on-chip RAM is exempt from the region rule. Software programs the permissions, the bitmap and the per-rule disables through a small write-only register port.

Top module: `bus_prot_monitor`

## Requirements
- R1: An access is counted on the clock edge where `bus_rd` or `bus_wr` is high and was low on the previous edge; a strobe held high for several cycles is one access, and a read strobe followed at once by a write strobe is two accesses.
- R2: Each chip enable i has a 2-bit permission at bits [2i+1:2i] of register 1: 00 allows reads and writes, 01 allows reads only, 10 and 11 allow nothing; a write through a read-only enable, or any access through a no-access enable, gives cause 01.
- R3: Region index is `bus_addr >> 15`; an access whose region bit in register 2 is 0 gives cause 10.
- R4: Addresses inside the on-chip RAM window (default 0x00000 to 0x01FFF) never give cause 10.
- R5: An access with every chip-enable line low gives cause 11.
- R6: Register 0 holds the rule disables: bit 0 turns off the chip-enable rule, bit 1 the region rule and bit 2 the missing-enable rule; a disabled rule never produces its cause.
- R7: When several rules fail on one access, the reported cause is 11 first, then 01, then 10.
- R8: An access while the monitor's own chip enable (default index 9) is high is never judged, whatever the other lines and settings are.
- R9: The cause of an access is reported as a one-cycle `brk_valid` pulse with `brk_cause` on the edge that counts the third later access; accesses without a violation produce no pulse.
- R10: Reset sets every permission to 00, every region bit to 1 and register 0 to 100 (missing-enable rule off), so no break is raised until software configures the block.
- R11: `cfg_we` writes `cfg_wdata` to register 0, 1 or 2 chosen by `cfg_addr`; a write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Bus address |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_ce | input | 12 | Chip-enable lines, active high |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| brk_valid | output | 1 | One-cycle break request |
| brk_cause | output | 2 | Cause code, valid with brk_valid |

## Verification
Directed patterns drive each rule alone: a read against a write through a read-only enable, an address inside against one outside the on-chip RAM window, and a strobe with no enable. These separate the three cause codes and show that the exemptions work. Stacked violations on a single access show the priority order. Accesses through the reserved enable show that it masks every rule. Held strobes and back-to-back read-then-write strobes show where access counting happens, and so where the three-access report delay lands. A long run of seeded random strobes, enable vectors, addresses and mid-run reconfigurations is then compared cycle by cycle with a bench model of the rules and of the delay.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_CE   = 2'b01,
        CAUSE_MAP  = 2'b10,
        CAUSE_NOCE = 2'b11
    } cause_e;

    localparam logic [1:0] PERM_RW = 2'b00;
    localparam logic [1:0] PERM_RO = 2'b01;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_PERM = 2'd1;
    localparam logic [1:0] REG_MAP  = 2'd2;

    // bit 2: missing-enable rule off, bit 1: region rule off, bit 0: enable rule off
    typedef struct packed {
        logic noce_off;
        logic map_off;
        logic ce_off;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{noce_off: 1'b1, map_off: 1'b0, ce_off: 1'b0};

    typedef struct packed {
        logic evt;
        logic is_wr;
    } acc_t;

    typedef struct packed {
        logic noce;
        logic ce;
        logic map;
    } viol_t;

    function automatic logic perm_forbids(input logic [1:0] perm, input logic is_wr);
        if (perm == PERM_RW)      return 1'b0;
        else if (perm == PERM_RO) return is_wr;
        else                      return 1'b1;
    endfunction

    function automatic cause_e pick_cause(input viol_t v);
        if (v.noce)     return CAUSE_NOCE;
        else if (v.ce)  return CAUSE_CE;
        else if (v.map) return CAUSE_MAP;
        else            return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/bpm_cfg_regs.sv
module bpm_cfg_regs
    import bpm_pkg::*;
#(
    parameter int NUM_CE     = 12,
    parameter int NUM_REGION = 32,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [1:0]            waddr,
    input  logic [DATA_W-1:0]     wdata,
    output ctrl_t                 ctrl,
    output logic [2*NUM_CE-1:0]   perm,
    output logic [NUM_REGION-1:0] map_en
);
    localparam int PERM_W = 2 * NUM_CE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RESET;
            perm   <= '0;
            map_en <= '1;
        end else if (we) begin
            case (waddr)
                REG_CTRL: ctrl   <= ctrl_t'(wdata[2:0]);
                REG_PERM: perm   <= wdata[PERM_W-1:0];
                REG_MAP:  map_en <= wdata[NUM_REGION-1:0];
                default:  ;
            endcase
        end
    end

    // R10
    reset_values_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (perm == '0 && map_en == '1 && ctrl == CTRL_RESET));

    // R11
    unused_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == 2'd3) |=> ($stable(perm) && $stable(map_en) && $stable(ctrl)));

endmodule

// File: rtl/bpm_access_detect.sv
module bpm_access_detect
    import bpm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd,
    input  logic wr,
    output acc_t acc
);
    logic rd_q;
    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd;
            wr_q <= wr;
        end
    end

    always_comb begin
        acc.evt   = (rd && !rd_q) || (wr && !wr_q);
        acc.is_wr = wr;
    end

    // R1
    held_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rd == $past(rd) && wr == $past(wr)) |-> !acc.evt);

    // R1
    evt_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        acc.evt |-> (rd || wr));

endmodule

// File: rtl/bpm_check.sv
module bpm_check
    import bpm_pkg::*;
#(
    parameter int              ADDR_W       = 20,
    parameter int              NUM_CE       = 12,
    parameter int              MON_CE       = 9,
    parameter int              REGION_SHIFT = 15,
    parameter int              NUM_REGION   = 32,
    parameter logic [ADDR_W-1:0] IRAM_BASE  = '0,
    parameter logic [ADDR_W-1:0] IRAM_SIZE  = 'h2000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  acc_t                  acc,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_CE-1:0]     ce,
    input  ctrl_t                 ctrl,
    input  logic [2*NUM_CE-1:0]   perm,
    input  logic [NUM_REGION-1:0] map_en,
    output cause_e                cause
);
    localparam int RIDX_W = ADDR_W - REGION_SHIFT;

    logic [NUM_CE-1:0]     ce_bad;
    logic [RIDX_W-1:0]     ridx;
    logic [ADDR_W-1:0]     iram_off;
    logic                  in_iram;
    logic                  mon_hit;
    viol_t                 viol;

    for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
        assign ce_bad[i] = ce[i] && perm_forbids(perm[2*i +: 2], acc.is_wr);
    end

    always_comb begin
        ridx      = addr[ADDR_W-1:REGION_SHIFT];
        iram_off  = addr - IRAM_BASE;
        in_iram   = iram_off < IRAM_SIZE;
        mon_hit   = ce[MON_CE];
        viol.noce = (ce == '0) && !ctrl.noce_off;
        viol.ce   = (|ce_bad) && !ctrl.ce_off;
        viol.map  = !map_en[ridx] && !in_iram && !ctrl.map_off;
        cause     = mon_hit ? CAUSE_NONE : pick_cause(viol);
    end

    // R4
    iram_no_map_chk: assert property (@(posedge clk) disable iff (rst)
        (cause == CAUSE_MAP) |-> !in_iram);

    // R5
    noce_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cause == CAUSE_NOCE) |-> (ce == '0));

    // R2
    ce_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (cause == CAUSE_CE) |-> (ce != '0 && !ctrl.ce_off));

    // R8
    reserved_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (cause != CAUSE_NONE) |-> !ce[MON_CE]);

endmodule

// File: rtl/bpm_report_pipe.sv
module bpm_report_pipe
    import bpm_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   evt,
    input  cause_e cause_in,
    output logic   brk_valid,
    output cause_e brk_cause
);
    cause_e stage [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)      stage[0] <= CAUSE_NONE;
                else if (evt) stage[0] <= cause_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)      stage[s] <= CAUSE_NONE;
                else if (evt) stage[s] <= stage[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_valid <= 1'b0;
            brk_cause <= CAUSE_NONE;
        end else begin
            brk_valid <= evt && (stage[DEPTH-1] != CAUSE_NONE);
            brk_cause <= evt ? stage[DEPTH-1] : CAUSE_NONE;
        end
    end

    // R9
    pulse_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        brk_valid |-> (brk_cause != CAUSE_NONE));

endmodule

// File: rtl/bus_prot_monitor.sv
module bus_prot_monitor
    import bpm_pkg::*;
#(
    parameter int                ADDR_W       = 20,
    parameter int                NUM_CE       = 12,
    parameter int                MON_CE       = 9,
    parameter int                REGION_SHIFT = 15,
    parameter int                DATA_W       = 32,
    parameter int                REPORT_DEPTH = 3,
    parameter logic [ADDR_W-1:0] IRAM_BASE    = '0,
    parameter logic [ADDR_W-1:0] IRAM_SIZE    = 'h2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [NUM_CE-1:0] bus_ce,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              brk_valid,
    output logic [1:0]        brk_cause
);
    localparam int NUM_REGION = 1 << (ADDR_W - REGION_SHIFT);

    ctrl_t                 ctrl;
    logic [2*NUM_CE-1:0]   perm;
    logic [NUM_REGION-1:0] map_en;
    acc_t                  acc;
    cause_e                cause;
    cause_e                rep_cause;

    bpm_cfg_regs #(
        .NUM_CE     (NUM_CE),
        .NUM_REGION (NUM_REGION),
        .DATA_W     (DATA_W)
    ) i_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .waddr  (cfg_addr),
        .wdata  (cfg_wdata),
        .ctrl   (ctrl),
        .perm   (perm),
        .map_en (map_en)
    );

    bpm_access_detect i_detect (
        .clk (clk),
        .rst (rst),
        .rd  (bus_rd),
        .wr  (bus_wr),
        .acc (acc)
    );

    bpm_check #(
        .ADDR_W       (ADDR_W),
        .NUM_CE       (NUM_CE),
        .MON_CE       (MON_CE),
        .REGION_SHIFT (REGION_SHIFT),
        .NUM_REGION   (NUM_REGION),
        .IRAM_BASE    (IRAM_BASE),
        .IRAM_SIZE    (IRAM_SIZE)
    ) i_check (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .addr   (bus_addr),
        .ce     (bus_ce),
        .ctrl   (ctrl),
        .perm   (perm),
        .map_en (map_en),
        .cause  (cause)
    );

    bpm_report_pipe #(
        .DEPTH (REPORT_DEPTH)
    ) i_pipe (
        .clk       (clk),
        .rst       (rst),
        .evt       (acc.evt),
        .cause_in  (cause),
        .brk_valid (brk_valid),
        .brk_cause (rep_cause)
    );

    assign brk_cause = rep_cause;

    // R9
    pulse_on_access_chk: assert property (@(posedge clk) disable iff (rst)
        brk_valid |-> $past(acc.evt));

endmodule

// File: tb/test_bus_prot_monitor.sv
module test_bus_prot_monitor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_ce = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        brk_valid;
    logic [1:0]  brk_cause;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_tag  = "R10";

    // bench model state
    logic [2:0]  m_ctrl;
    logic [23:0] m_perm;
    logic [31:0] m_map;
    logic        m_prd, m_pwr;
    logic [1:0]  m_pipe [3];

    always #5 clk = ~clk;

    bus_prot_monitor i_bus_prot_monitor (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_ce    (bus_ce),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .brk_valid (brk_valid),
        .brk_cause (brk_cause)
    );

    function automatic logic [1:0] model_cause(input logic wr, input logic [11:0] ce,
                                               input logic [19:0] a);
        logic noce, cev, mapv;
        if (ce[9]) return 2'b00;
        noce = (ce == 12'd0) && !m_ctrl[2];
        cev  = 1'b0;
        for (int i = 0; i < 12; i++) begin
            logic [1:0] p;
            p = m_perm[2*i +: 2];
            if (ce[i] && (p[1] || (p == 2'b01 && wr))) cev = 1'b1;
        end
        cev  = cev && !m_ctrl[0];
        mapv = !m_map[a[19:15]] && (a >= 20'h02000) && !m_ctrl[1];
        if (noce) return 2'b11;
        if (cev)  return 2'b01;
        if (mapv) return 2'b10;
        return 2'b00;
    endfunction

    task automatic check_out(input logic ev, input logic [1:0] ec);
        n_checks++;
        if (brk_valid !== ev || (ev && brk_cause !== ec)) begin
            n_fail++;
            $display("FAIL %s: brk_valid=%0b brk_cause=%0d expected valid=%0b cause=%0d",
                     cur_tag, brk_valid, brk_cause, ev, ec);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 3'b100;
        m_perm = '0;
        m_map  = '1;
        m_prd  = 1'b0;
        m_pwr  = 1'b0;
        for (int i = 0; i < 3; i++) m_pipe[i] = 2'b00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0; bus_ce = '0; cfg_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        check_out(1'b0, 2'b00);
    endtask

    task automatic cyc(input logic rd, input logic wr, input logic [11:0] ce,
                       input logic [19:0] a);
        logic       evt;
        logic       ev;
        logic [1:0] ec, nc;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_ce = ce; bus_addr = a; cfg_we = 1'b0;
        nc  = model_cause(wr, ce, a);
        evt = (rd && !m_prd) || (wr && !m_pwr);
        ev  = 1'b0;
        ec  = 2'b00;
        @(posedge clk);
        if (evt) begin
            ev = (m_pipe[2] != 2'b00);
            ec = m_pipe[2];
            m_pipe[2] = m_pipe[1];
            m_pipe[1] = m_pipe[0];
            m_pipe[0] = nc;
        end
        m_prd = rd;
        m_pwr = wr;
        #1;
        check_out(ev, ec);
    endtask

    task automatic access(input logic wr, input logic [11:0] ce, input logic [19:0] a);
        cyc(!wr, wr, ce, a);
        cyc(1'b0, 1'b0, ce, a);
    endtask

    task automatic cfg_write(input logic [1:0] ad, input logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_ce = '0;
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(posedge clk);
        m_prd = 1'b0;
        m_pwr = 1'b0;
        case (ad)
            2'd0: m_ctrl = d[2:0];
            2'd1: m_perm = d[23:0];
            2'd2: m_map  = d;
            default: ;
        endcase
        #1;
        check_out(1'b0, 2'b00);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic flush3();
        for (int i = 0; i < 3; i++) access(1'b0, 12'h001, 20'h00100);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        do_reset();

        // R10: defaults let everything pass, even missing enables
        cur_tag = "R10";
        access(1'b0, 12'h000, 20'h40000);
        access(1'b1, 12'h004, 20'hF8000);
        flush3();

        // R11 and R5: enable all rules, then a strobe with no enable
        cur_tag = "R11/R5/R9";
        cfg_write(2'd0, 32'h0);
        access(1'b0, 12'h000, 20'h12345);
        flush3();

        // R2: read-only enable 1, no-access enables 2 and 3
        cur_tag = "R2";
        cfg_write(2'd1, 32'h0000_00E4);
        access(1'b1, 12'h002, 20'h00200);
        access(1'b0, 12'h002, 20'h00200);
        access(1'b0, 12'h004, 20'h00200);
        access(1'b0, 12'h008, 20'h00200);
        flush3();

        // R3 and R4: clear regions 0 and 5
        cur_tag = "R3/R4";
        cfg_write(2'd2, 32'hFFFF_FFDE);
        access(1'b0, 12'h001, 20'h2A000);
        access(1'b0, 12'h001, 20'h01000);
        access(1'b1, 12'h001, 20'h01FFF);
        access(1'b0, 12'h001, 20'h03000);
        flush3();

        // R7: stacked violations
        cur_tag = "R7";
        access(1'b0, 12'h000, 20'h2A000);
        access(1'b1, 12'h004, 20'h2A000);
        access(1'b1, 12'h002, 20'h2B000);
        flush3();

        // R8: reserved enable masks every rule
        cur_tag = "R8";
        cfg_write(2'd1, 32'h0008_00E4);
        access(1'b0, 12'h200, 20'h2A000);
        access(1'b1, 12'h204, 20'h2A000);
        flush3();

        // R6: each disable bit
        cur_tag = "R6";
        cfg_write(2'd0, 32'h1);
        access(1'b1, 12'h002, 20'h00100);
        flush3();
        cfg_write(2'd0, 32'h2);
        access(1'b0, 12'h001, 20'h2A000);
        access(1'b1, 12'h002, 20'h2A000);
        flush3();
        cfg_write(2'd0, 32'h4);
        access(1'b0, 12'h000, 20'h2A000);
        flush3();
        cfg_write(2'd0, 32'h0);

        // R1: held strobes and back-to-back read then write
        cur_tag = "R1";
        access(1'b0, 12'h000, 20'h00100);
        cyc(1'b1, 1'b0, 12'h001, 20'h00100);
        cyc(1'b1, 1'b0, 12'h001, 20'h00100);
        cyc(1'b1, 1'b0, 12'h001, 20'h00100);
        cyc(1'b0, 1'b1, 12'h001, 20'h00100);
        cyc(1'b0, 1'b1, 12'h001, 20'h00100);
        cyc(1'b1, 1'b1, 12'h001, 20'h00100);
        cyc(1'b0, 1'b0, 12'h001, 20'h00100);
        flush3();

        // R11: unused address changes nothing
        cur_tag = "R11";
        cfg_write(2'd3, 32'h0);
        access(1'b0, 12'h001, 20'h00100);
        access(1'b1, 12'h001, 20'h40000);
        flush3();

        // random mix against the model
        cur_tag = "R9 random";
        for (int it = 0; it < 3000; it++) begin
            if (it % 60 == 0) begin
                cfg_write(2'($urandom_range(0, 3)), $urandom());
            end else begin
                logic [11:0] ce;
                int sel;
                sel = $urandom_range(0, 9);
                if (sel == 0)      ce = 12'h000;
                else if (sel == 1) ce = 12'h200 | (12'h1 << $urandom_range(0, 11));
                else if (sel == 2) ce = 12'($urandom()) & 12'hDFF;
                else               ce = 12'h1 << $urandom_range(0, 11);
                cyc(($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0), ce,
                    20'($urandom()));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule